// File: doc/BRIEF.md
# DMA Request Arbitration Sequencer

This block sits between the request lines of up to 32 peripherals and a simple memory mover. Each channel has two request inputs: a single-item request and a burst request. The block keeps a small state record for every channel. The record holds an enable bit, a flag that admits only burst requests, an arbitration-size exponent, a flag that selects the alternate control entry, and the count of items still to move. Among the eligible channels, the lowest-numbered one wins. A grant becomes a run of item strobes on a req/ack handshake. A single-item grant is one strobe. A burst grant is as many strobes as the smaller of the arbitration size and the remaining count.

While a grant is active, the block drives the address of the granted channel's control entry. The entries form a table aligned to 1024 bytes. Entries are 16 bytes each. Primary entries fill the lower 512 bytes and alternate entries fill the upper 512 bytes. The remaining count drops by one on every acknowledged item. When it reaches zero, the channel raises a one-cycle completion flag, disables itself, and ignores requests until a new configuration write arrives.

Configuration is written one channel at a time through a write strobe. Writing a channel loads all of its fields. The channel is enabled only when the loaded count is non-zero.

Top module: `dma_req_sequencer`

## Requirements
- R1: A single request on an enabled channel that is not burst-only, with no burst request on that channel, moves exactly one item; the channel then stays quiet until it requests again.
- R2: A burst request moves min(2^E, remaining count) items back-to-back, where E is the channel's 4-bit exponent field; any exponent above 10 acts as 10 (1024 items).
- R3: Once a grant has started, every item of it goes to the same channel, without interruption, even while a lower-numbered channel requests; xfer_req_o stays high between its items.
- R4: On a channel whose burst-only flag is set, single requests are ignored (no item moves, the channel stays enabled); burst requests are still serviced.
- R5: When several channels are eligible at an arbitration point, the lowest channel number wins; a channel raising both request types is treated as a burst.
- R6: While xfer_req_o is high, ctl_addr_o = {ctl_base_i, A, xfer_ch_o, 4'b0000}, with A = 1 when the channel's alternate flag is set: the primary entry is at base + 16·channel and the alternate entry is 512 bytes higher.
- R7: While xfer_req_o is high and xfer_ack_i is low, the request, channel and address hold and no item is counted; each cycle with both high counts one item.
- R8: The acknowledge of the last remaining item sets that channel's done_o bit for exactly one cycle in the following cycle, clears its ch_en_o bit, and later requests on the channel move nothing until it is configured again.
- R9: After reset, all channels are disabled, xfer_req_o is low and done_o is zero; a configuration write with a count of zero leaves the channel disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_base_i | input | 22 | Control table base, address bits 31:10 |
| single_req_i | input | 32 | Single-item request per channel |
| burst_req_i | input | 32 | Burst request per channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 5 | Channel written |
| cfg_count_i | input | 16 | Items to move; zero leaves the channel disabled |
| cfg_exp_i | input | 4 | Arbitration size exponent |
| cfg_burst_only_i | input | 1 | Admit burst requests only |
| cfg_alt_i | input | 1 | Use the alternate control entry |
| xfer_req_o | output | 1 | Item transfer request to the memory mover |
| xfer_ack_i | input | 1 | Item accepted by the memory mover |
| xfer_ch_o | output | 5 | Channel of the current grant |
| ctl_addr_o | output | 32 | Control entry address of the granted channel |
| ch_en_o | output | 32 | Per-channel enable |
| done_o | output | 32 | Per-channel completion pulse |

## Verification
The checker watches handshake stability under back-pressure, the fixed channel inside a grant, and the address composition on every cycle. It also checks that completion pulses are single-cycle and one-hot, that they clear the enable, that only enabled channels are granted, and that a burst-only channel is granted only in response to a burst request. The number of items per grant, the minimum against the remaining count, the exponent clamp, the priority order and the exact order of items around a burst that other channels are waiting on depend on counts and request history. Only the directed scenarios in the bench can show these, by logging every acknowledged item.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    // Largest arbitration exponent honoured (2**10 = 1024 items)
    localparam int MAX_EXP = 10;

    typedef enum logic {
        ST_IDLE,
        ST_MOVE
    } seq_st_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // Lowest set index wins: scan downward so the lowest index is written last
    always_comb begin
        valid_o = |elig_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int CNT_W  = 16,
    parameter int EXP_W  = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           cfg_we_i,
    input  logic [CH_W-1:0]                cfg_ch_i,
    input  logic [CNT_W-1:0]               cfg_count_i,
    input  logic [EXP_W-1:0]               cfg_exp_i,
    input  logic                           cfg_burst_only_i,
    input  logic                           cfg_alt_i,
    input  logic                           dec_i,
    input  logic [CH_W-1:0]                dec_ch_i,
    output logic [NUM_CH-1:0]              en_o,
    output logic [NUM_CH-1:0]              bonly_o,
    output logic [NUM_CH-1:0]              alt_o,
    output logic [NUM_CH-1:0][EXP_W-1:0]   exp_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_o,
    output logic [NUM_CH-1:0]              done_o
);
    typedef struct packed {
        logic             en;
        logic             bonly;
        logic             alt;
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ch_rec_t;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_rec_t rec_d, rec_q;

        always_comb begin
            rec_d      = rec_q;
            rec_d.done = 1'b0;
            if (cfg_we_i && cfg_ch_i == CH_W'(c)) begin
                rec_d.cnt   = cfg_count_i;
                rec_d.exp   = cfg_exp_i;
                rec_d.bonly = cfg_burst_only_i;
                rec_d.alt   = cfg_alt_i;
                rec_d.en    = (cfg_count_i != '0);
            end else if (dec_i && dec_ch_i == CH_W'(c)) begin
                rec_d.cnt = rec_q.cnt - CNT_W'(1);
                if (rec_q.cnt == CNT_W'(1)) begin
                    rec_d.en   = 1'b0;
                    rec_d.done = 1'b1;
                end
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) rec_q <= '0;
            else         rec_q <= rec_d;
        end

        assign en_o[c]    = rec_q.en;
        assign bonly_o[c] = rec_q.bonly;
        assign alt_o[c]   = rec_q.alt;
        assign exp_o[c]   = rec_q.exp;
        assign cnt_o[c]   = rec_q.cnt;
        assign done_o[c]  = rec_q.done;
    end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_seq_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int CNT_W = 16,
    parameter int EXP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             grant_vld_i,
    input  logic [CH_W-1:0]  grant_ch_i,
    input  logic             grant_burst_i,
    input  logic [CNT_W-1:0] grant_cnt_i,
    input  logic [EXP_W-1:0] grant_exp_i,
    input  logic             xfer_ack_i,
    output logic             xfer_req_o,
    output logic [CH_W-1:0]  xfer_ch_o,
    output logic             dec_o,
    output logic [CH_W-1:0]  dec_ch_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] left;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic [EXP_W-1:0] exp_c;
    logic [CNT_W-1:0] blen;
    logic [CNT_W-1:0] len;

    always_comb begin
        exp_c = (grant_exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : grant_exp_i;
        blen  = CNT_W'(1) << exp_c;
        len   = grant_burst_i ? ((grant_cnt_i < blen) ? grant_cnt_i : blen)
                              : CNT_W'(1);
        s_d   = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (grant_vld_i) begin
                    s_d.st   = ST_MOVE;
                    s_d.ch   = grant_ch_i;
                    s_d.left = len;
                end
            end
            ST_MOVE: begin
                if (xfer_ack_i) begin
                    s_d.left = s_q.left - CNT_W'(1);
                    if (s_q.left == CNT_W'(1)) s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, ch: '0, left: '0};
        else         s_q <= s_d;
    end

    assign xfer_req_o = (s_q.st == ST_MOVE);
    assign xfer_ch_o  = s_q.ch;
    assign dec_o      = xfer_req_o && xfer_ack_i;
    assign dec_ch_o   = s_q.ch;
endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer #(
    parameter int NUM_CH      = 32,
    parameter int CNT_W       = 16,
    parameter int EXP_W       = 4,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 16,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int ENTRY_SH   = $clog2(ENTRY_BYTES),
    localparam int TABLE_SH   = 1 + CH_W + ENTRY_SH,
    localparam int BASE_W     = ADDR_W - TABLE_SH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BASE_W-1:0] ctl_base_i,
    input  logic [NUM_CH-1:0] single_req_i,
    input  logic [NUM_CH-1:0] burst_req_i,
    input  logic              cfg_we_i,
    input  logic [CH_W-1:0]   cfg_ch_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic [EXP_W-1:0]  cfg_exp_i,
    input  logic              cfg_burst_only_i,
    input  logic              cfg_alt_i,
    output logic              xfer_req_o,
    input  logic              xfer_ack_i,
    output logic [CH_W-1:0]   xfer_ch_o,
    output logic [ADDR_W-1:0] ctl_addr_o,
    output logic [NUM_CH-1:0] ch_en_o,
    output logic [NUM_CH-1:0] done_o
);
    logic [NUM_CH-1:0]            bonly_v;
    logic [NUM_CH-1:0]            alt_v;
    logic [NUM_CH-1:0][EXP_W-1:0] exp_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
    logic [NUM_CH-1:0]            elig;
    logic                         pick_vld;
    logic [CH_W-1:0]              pick_idx;
    logic                         dec;
    logic [CH_W-1:0]              dec_ch;

    dma_chan_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .CNT_W  (CNT_W),
        .EXP_W  (EXP_W)
    ) bank_i (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .cfg_we_i         (cfg_we_i),
        .cfg_ch_i         (cfg_ch_i),
        .cfg_count_i      (cfg_count_i),
        .cfg_exp_i        (cfg_exp_i),
        .cfg_burst_only_i (cfg_burst_only_i),
        .cfg_alt_i        (cfg_alt_i),
        .dec_i            (dec),
        .dec_ch_i         (dec_ch),
        .en_o             (ch_en_o),
        .bonly_o          (bonly_v),
        .alt_o            (alt_v),
        .exp_o            (exp_v),
        .cnt_o            (cnt_v),
        .done_o           (done_o)
    );

    // A channel competes when enabled and raising a request it admits
    assign elig = ch_en_o & (burst_req_i | (single_req_i & ~bonly_v));

    dma_prio_pick #(
        .N  (NUM_CH),
        .IW (CH_W)
    ) pick_i (
        .elig_i  (elig),
        .valid_o (pick_vld),
        .idx_o   (pick_idx)
    );

    dma_xfer_fsm #(
        .CH_W  (CH_W),
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) fsm_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .grant_vld_i   (pick_vld),
        .grant_ch_i    (pick_idx),
        .grant_burst_i (burst_req_i[pick_idx]),
        .grant_cnt_i   (cnt_v[pick_idx]),
        .grant_exp_i   (exp_v[pick_idx]),
        .xfer_ack_i    (xfer_ack_i),
        .xfer_req_o    (xfer_req_o),
        .xfer_ch_o     (xfer_ch_o),
        .dec_o         (dec),
        .dec_ch_o      (dec_ch)
    );

    // Aligned table: base, half select, channel slot, byte offset zero
    assign ctl_addr_o = {ctl_base_i, alt_v[xfer_ch_o], xfer_ch_o, {ENTRY_SH{1'b0}}};
endmodule

// File: rtl/dma_req_sequencer_chk.sv
module dma_req_sequencer_chk #(
    parameter int NUM_CH      = 32,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 16,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int ENTRY_SH   = $clog2(ENTRY_BYTES),
    localparam int TABLE_SH   = 1 + CH_W + ENTRY_SH,
    localparam int BASE_W     = ADDR_W - TABLE_SH
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [BASE_W-1:0] ctl_base_i,
    input logic [NUM_CH-1:0] burst_req_i,
    input logic              xfer_req_o,
    input logic              xfer_ack_i,
    input logic [CH_W-1:0]   xfer_ch_o,
    input logic [ADDR_W-1:0] ctl_addr_o,
    input logic [NUM_CH-1:0] ch_en_o,
    input logic [NUM_CH-1:0] done_o,
    input logic [NUM_CH-1:0] bonly_v
);
    logic [NUM_CH-1:0] breq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) breq_q <= '0;
        else         breq_q <= burst_req_i;
    end

    p_hold_under_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_req_o && !xfer_ack_i) |=>
            (xfer_req_o && $stable(xfer_ch_o) && $stable(ctl_addr_o)));

    p_grant_not_preempted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_req_o && $past(xfer_req_o)) |-> (xfer_ch_o == $past(xfer_ch_o)));

    p_entry_address_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_req_o |-> (ctl_addr_o[ADDR_W-1:TABLE_SH] == ctl_base_i
                        && ctl_addr_o[ENTRY_SH+CH_W-1:ENTRY_SH] == xfer_ch_o
                        && ctl_addr_o[ENTRY_SH-1:0] == '0));

    p_done_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(done_o));

    p_done_single_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o != '0) |=> ((done_o & $past(done_o)) == '0));

    p_done_disables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o != '0) |-> ((done_o & ch_en_o) == '0));

    p_grant_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xfer_req_o) |-> ch_en_o[xfer_ch_o]);

    p_burst_only_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(xfer_req_o) && bonly_v[xfer_ch_o]) |-> breq_q[xfer_ch_o]);
endmodule

bind dma_req_sequencer dma_req_sequencer_chk #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .ENTRY_BYTES (ENTRY_BYTES)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_base_i  (ctl_base_i),
    .burst_req_i (burst_req_i),
    .xfer_req_o  (xfer_req_o),
    .xfer_ack_i  (xfer_ack_i),
    .xfer_ch_o   (xfer_ch_o),
    .ctl_addr_o  (ctl_addr_o),
    .ch_en_o     (ch_en_o),
    .done_o      (done_o),
    .bonly_v     (bonly_v)
);

// File: tb/dma_req_sequencer_tb_top.sv
`timescale 1ns/1ps
module dma_req_sequencer_tb_top;
    localparam logic [21:0] BASE      = 22'h12345;
    localparam logic [31:0] BASE_ADDR = {BASE, 10'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] single_req = '0;
    logic [31:0] burst_req = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_ch = '0;
    logic [15:0] cfg_count = '0;
    logic [3:0]  cfg_exp = '0;
    logic        cfg_bonly = 1'b0;
    logic        cfg_alt = 1'b0;
    logic        xfer_req;
    logic        xfer_ack = 1'b0;
    logic        ack_en = 1'b1;
    logic [4:0]  xfer_ch;
    logic [31:0] ctl_addr;
    logic [31:0] ch_en;
    logic [31:0] done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    int log_ch [0:4095];
    logic [31:0] log_addr [0:4095];
    int log_n = 0;
    int beats [0:31];
    int done_cnt [0:31];

    always #2.5 clk = ~clk;

    dma_req_sequencer dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .ctl_base_i       (BASE),
        .single_req_i     (single_req),
        .burst_req_i      (burst_req),
        .cfg_we_i         (cfg_we),
        .cfg_ch_i         (cfg_ch),
        .cfg_count_i      (cfg_count),
        .cfg_exp_i        (cfg_exp),
        .cfg_burst_only_i (cfg_bonly),
        .cfg_alt_i        (cfg_alt),
        .xfer_req_o       (xfer_req),
        .xfer_ack_i       (xfer_ack),
        .xfer_ch_o        (xfer_ch),
        .ctl_addr_o       (ctl_addr),
        .ch_en_o          (ch_en),
        .done_o           (done)
    );

    // Memory mover model and item logger: an item counted here is accepted at the next rising edge
    initial begin
        for (int i = 0; i < 32; i++) begin
            beats[i] = 0;
            done_cnt[i] = 0;
        end
        forever begin
            @(negedge clk);
            #1;
            if (xfer_req && ack_en && log_n < 4096) begin
                log_ch[log_n] = int'(xfer_ch);
                log_addr[log_n] = ctl_addr;
                log_n++;
                beats[xfer_ch]++;
            end
            for (int i = 0; i < 32; i++) if (done[i]) done_cnt[i]++;
            xfer_ack <= xfer_req & ack_en;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    endtask

    task automatic cfg(input int ch, input int count, input int e, input bit bo, input bit alt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 5'(ch); cfg_count = 16'(count);
        cfg_exp = 4'(e); cfg_bonly = bo; cfg_alt = alt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] s, input logic [31:0] b);
        @(negedge clk);
        single_req = s; burst_req = b;
        @(negedge clk);
        single_req = '0; burst_req = '0;
    endtask

    task automatic wait_idle();
        int idle = 0;
        int guard = 0;
        while (idle < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (!xfer_req) idle++; else idle = 0;
        end
    endtask

    task automatic t_reset();
        chk("R9 reset xfer_req", xfer_req, 0);
        chk("R9 reset ch_en", ch_en, 0);
        chk("R9 reset done", done, 0);
    endtask

    task automatic t_single();
        int b0 = beats[3];
        int n0 = log_n;
        cfg(3, 10, 2, 0, 0);
        pulse(32'd1 << 3, '0);
        wait_idle();
        chk("R1 single moves one item", beats[3] - b0, 1);
        chk("R1 channel still enabled", ch_en[3], 1);
        chk("R6 primary entry address", log_addr[n0], BASE_ADDR + 48);
    endtask

    task automatic t_burst();
        int b0;
        cfg(5, 10, 2, 0, 0);
        b0 = beats[5]; pulse('0, 32'd1 << 5); wait_idle();
        chk("R2 first burst length", beats[5] - b0, 4);
        b0 = beats[5]; pulse('0, 32'd1 << 5); wait_idle();
        chk("R2 second burst length", beats[5] - b0, 4);
        b0 = beats[5]; pulse('0, 32'd1 << 5); wait_idle();
        chk("R2 burst limited by remaining", beats[5] - b0, 2);
        chk("R8 one done pulse", done_cnt[5], 1);
        chk("R8 enable cleared", ch_en[5], 0);
        b0 = beats[5]; pulse(32'd1 << 5, 32'd1 << 5); wait_idle();
        chk("R8 request after done ignored", beats[5] - b0, 0);
        cfg(5, 3, 2, 0, 0);
        b0 = beats[5]; pulse('0, 32'd1 << 5); wait_idle();
        chk("R8 re-enabled channel moves again", beats[5] - b0, 3);
        chk("R8 second done pulse", done_cnt[5], 2);
    endtask

    task automatic t_clamp();
        int b0;
        cfg(11, 1100, 15, 0, 0);
        b0 = beats[11]; pulse('0, 32'd1 << 11); wait_idle();
        chk("R2 exponent clamped to 1024", beats[11] - b0, 1024);
        b0 = beats[11]; pulse('0, 32'd1 << 11); wait_idle();
        chk("R2 clamp tail", beats[11] - b0, 76);
    endtask

    task automatic t_bonly();
        int b0;
        cfg(7, 5, 1, 1, 0);
        b0 = beats[7]; pulse(32'd1 << 7, '0); wait_idle();
        chk("R4 single ignored on burst-only", beats[7] - b0, 0);
        chk("R4 channel stays enabled", ch_en[7], 1);
        b0 = beats[7]; pulse('0, 32'd1 << 7); wait_idle();
        chk("R4 burst serviced on burst-only", beats[7] - b0, 2);
    endtask

    task automatic t_prio();
        int n0;
        int b0;
        cfg(2, 2, 0, 0, 0);
        cfg(9, 2, 0, 0, 0);
        n0 = log_n;
        @(negedge clk);
        single_req = (32'd1 << 2) | (32'd1 << 9);
        wait_idle();
        single_req = '0;
        chk("R5 item 0 lowest channel", log_ch[n0], 2);
        chk("R5 item 1 lowest channel", log_ch[n0 + 1], 2);
        chk("R5 item 2 next channel", log_ch[n0 + 2], 9);
        chk("R5 item count", log_n - n0, 4);
        cfg(6, 8, 2, 0, 0);
        b0 = beats[6]; pulse(32'd1 << 6, 32'd1 << 6); wait_idle();
        chk("R5 burst wins over single", beats[6] - b0, 4);
    endtask

    task automatic t_preempt();
        int n0;
        int ok = 1;
        cfg(10, 20, 3, 0, 0);
        cfg(1, 3, 0, 0, 0);
        n0 = log_n;
        pulse('0, 32'd1 << 10);
        repeat (2) @(negedge clk);
        single_req = 32'd1 << 1;
        wait_idle();
        single_req = '0;
        for (int i = 0; i < 8; i++) if (log_ch[n0 + i] != 10) ok = 0;
        chk("R3 burst items uninterrupted", ok, 1);
        chk("R3 waiting channel served after burst", log_ch[n0 + 8], 1);
        chk("R3 total items", log_n - n0, 11);
    endtask

    task automatic t_alt();
        int n0 = log_n;
        cfg(4, 1, 0, 0, 1);
        pulse(32'd1 << 4, '0);
        wait_idle();
        chk("R6 alternate entry address", log_addr[n0], BASE_ADDR + 512 + 64);
    endtask

    task automatic t_stall();
        int b0 = beats[13];
        cfg(13, 4, 2, 0, 0);
        @(negedge clk);
        ack_en = 1'b0;
        pulse('0, 32'd1 << 13);
        repeat (6) @(negedge clk);
        chk("R7 no item while ack low", beats[13] - b0, 0);
        chk("R7 request held", xfer_req, 1);
        chk("R7 channel held", xfer_ch, 13);
        ack_en = 1'b1;
        wait_idle();
        chk("R7 items after release", beats[13] - b0, 4);
        chk("R7 done after release", done_cnt[13], 1);
    endtask

    task automatic t_zero();
        int b0 = beats[12];
        cfg(12, 0, 2, 0, 0);
        chk("R9 zero count leaves disabled", ch_en[12], 0);
        pulse(32'd1 << 12, 32'd1 << 12);
        wait_idle();
        chk("R9 disabled channel moves nothing", beats[12] - b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_clamp();
        t_bonly();
        t_prio();
        t_preempt();
        t_alt();
        t_stall();
        t_zero();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule